// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block sits next to a small 8-bit CPU core. It decides which pending interrupt the core services next, and it tells the core where that handler's address is stored. Nineteen hardware event lines feed fifteen maskable slots. Eight of these lines are external pins with edge detection; the other eleven are single-cycle pulses from timers, serial channels and the A/D converter. Five of the slots can each be switched between two sources by a select bit. Reset and a software break request complete a fixed ladder of seventeen priority levels: reset at the top, break at the bottom.

A maskable slot is taken only when three conditions hold at once: its request flag is set, its enable flag is set, and the global disable flag is clear. When a request is taken, the controller raises a pending line and latches the 16-bit address of the low byte of the vector pair. It then waits for an acknowledge from the core. Software reaches the flags through a small register file, with one write port and one combinational read port.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset is released, the first clock edge presents the reset vector: `irqPending`=1 and `vecAddr`=16'hFFFC. The register reset values are: request flags 0, enable flags 0, select flags 0, pin polarity 8'hFF, and disable flag 1.
- R2: A maskable slot is taken only when its request flag is 1, its enable flag is 1 and the disable flag is 0. If any of the three is missing, the request flag stays set and `irqPending` stays 0.
- R3: Slot s (0..14) is priority level s+2. When several slots are eligible, the lowest slot index is taken. Level L presents vector 16'hFFFC - 2*(L-1).
- R4: Source numbering is as follows. Pins 0..7 are sources 0..7. `periphEvt` bit p is source 8+p. Slot primaries, in slot order, are the sources 0,1,9,10,11,12,13,14,5,6,16,2,3,4,17. Slots 0, 9, 10, 13 and 14 have alternates 8, 15, 8, 7 and 18. Select bit s=1 picks the alternate. Events from the source that is not selected leave the request flags unchanged.
- R5: Each pin passes through a two-stage synchronizer, and an edge on it sets its request flag at the third clock edge after the pin changes. A polarity bit of 1 detects rising edges and 0 detects falling edges. The edge of the other direction is ignored.
- R6: When a slot is taken, its request flag is cleared and the disable flag is set, in the same clock edge. Any take, including reset and break, sets the disable flag.
- R7: `vecAddr` and `irqPending`=1 hold unchanged until `intAck` is sampled high. The edge after that drops `irqPending`, and no new take happens on that same edge.
- R8: Break (`brkReq` held high) is level 17 with vector 16'hFFDC. It ignores the disable flag and has no flags of its own. It is taken only when no maskable slot is eligible.
- R9: Writing the request register clears every flag whose data bit is 0 and leaves flags whose data bit is 1 as they were. A hardware event in the same cycle as the write still sets its flag.
- R10: The register offsets are 0 for requests, 1 for enables, 2 for selects, 3 for pin polarity (bits 7:0), and 4 for control (bit 0 = disable flag). Reads return the stored values, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| extPins | input | 8 | Asynchronous external interrupt pins |
| periphEvt | input | 11 | Single-cycle internal event pulses |
| brkReq | input | 1 | Software break request, held until acknowledged |
| intAck | input | 1 | Core acknowledge of the presented vector |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write offset |
| wrData | input | 15 | Register write data |
| rdAddr | input | 3 | Register read offset |
| rdData | output | 15 | Register read data |
| irqPending | output | 1 | A vector is presented and awaits acknowledge |
| vecAddr | output | 16 | Low-byte address of the presented vector pair |

## Verification
The assertions assume four things about the inputs. The core raises `intAck` only while `irqPending` is high. `brkReq` stays high until its vector is acknowledged and drops in the same cycle as that acknowledge. Peripheral events last one cycle. Pin levels are held long enough for the synchronizer to see each edge. The stimulus holds every pin level for four cycles, pulses events for exactly one cycle, acknowledges only after checking that a vector is pending, and releases break together with the acknowledge that retires it.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SLOTS   = 15;
  localparam int NUM_PINS    = 8;
  localparam int NUM_PEVT    = 11;
  localparam int SYNC_STAGES = 2;
  localparam int NUM_SRC     = NUM_PINS + NUM_PEVT;
  localparam int SLOT_W      = $clog2(NUM_SLOTS);
  localparam int ADDR_W      = 3;
  localparam int DATA_W      = NUM_SLOTS;
  localparam int VEC_W       = 16;
  localparam int BRK_LEVEL   = NUM_SLOTS + 2;
  localparam int LVL_W       = $clog2(BRK_LEVEL + 1);
  localparam logic [VEC_W-1:0] VEC_TOP = 16'hFFFC;

  typedef enum logic [ADDR_W-1:0] {
    REG_REQ = 3'd0,
    REG_EN  = 3'd1,
    REG_SEL = 3'd2,
    REG_POL = 3'd3,
    REG_CTL = 3'd4
  } regAddr_e;

  typedef enum logic [1:0] {
    TK_NONE  = 2'd0,
    TK_RESET = 2'd1,
    TK_MASK  = 2'd2,
    TK_BREAK = 2'd3
  } takeKind_e;

  typedef struct packed {
    logic      take;
    takeKind_e kind;
  } ctlStrobe_t;

  // Source index driving a slot when its select bit is 0.
  function automatic int primarySrc(input int slot);
    case (slot)
      0:  return 0;
      1:  return 1;
      2:  return 9;
      3:  return 10;
      4:  return 11;
      5:  return 12;
      6:  return 13;
      7:  return 14;
      8:  return 5;
      9:  return 6;
      10: return 16;
      11: return 2;
      12: return 3;
      13: return 4;
      default: return 17;
    endcase
  endfunction

  // Source index driving a slot when its select bit is 1.
  function automatic int altSrc(input int slot);
    case (slot)
      0:  return 8;
      9:  return 15;
      10: return 8;
      13: return 7;
      14: return 18;
      default: return primarySrc(slot);
    endcase
  endfunction
endpackage

// File: rtl/intc_pin_edge.sv
module intc_pin_edge
  import intc_pkg::*;
#(
  parameter int PINS   = NUM_PINS,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] pins,
  input  logic [PINS-1:0] polarity,
  output logic [PINS-1:0] edges
);
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    logic              prevLvl;
    logic              synced;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain   <= '0;
        prevLvl <= 1'b0;
      end else begin
        chain   <= {chain[STAGES-2:0], pins[p]};
        prevLvl <= chain[STAGES-1];
      end
    end

    assign synced   = chain[STAGES-1];
    assign edges[p] = polarity[p] ? (synced & ~prevLvl) : (~synced & prevLvl);

    // R5: a detected edge is a single-cycle event
    a_r5_single_edge: assert property (@(posedge clk) disable iff (rst)
      edges[p] |=> !edges[p]);
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int SLOTS = NUM_SLOTS,
  parameter int PINS  = NUM_PINS,
  parameter int PEVT  = NUM_PEVT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PINS-1:0]    pinEdge,
  input  logic [PEVT-1:0]    periphEvt,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [SLOTS-1:0]   wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  input  ctlStrobe_t         strobe,
  output logic [SLOTS-1:0]   rdData,
  output logic [PINS-1:0]    polBits,
  output logic               maskHit,
  output logic [VEC_W-1:0]   vecAddr
);
  localparam int SRCS = PINS + PEVT;

  logic [SRCS-1:0]   srcVec;
  logic [SLOTS-1:0]  slotEvt;
  logic [SLOTS-1:0]  reqFlags, enFlags, selBits;
  logic              disFlag;
  logic [SLOTS-1:0]  eligible, winMask, reqKeep, reqClr;
  logic [SLOT_W-1:0] winIdx;
  logic [LVL_W-1:0]  takeLvl;
  logic [VEC_W-1:0]  vecReg;
  logic              takeMask;

  assign srcVec = {periphEvt, pinEdge};

  // Per-slot source multiplexer; unshared slots map both choices to one source.
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    localparam int PRI = primarySrc(s);
    localparam int ALT = altSrc(s);
    assign slotEvt[s] = selBits[s] ? srcVec[ALT] : srcVec[PRI];
  end

  assign eligible = reqFlags & enFlags;
  assign maskHit  = !disFlag && (|eligible);
  assign winMask  = eligible & (~eligible + SLOTS'(1));

  always_comb begin
    winIdx = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (eligible[i]) winIdx = SLOT_W'(i);
    end
  end

  assign takeMask = strobe.take && (strobe.kind == TK_MASK);
  assign reqKeep  = (wrEn && wrAddr == REG_REQ) ? wrData : '1;
  assign reqClr   = takeMask ? winMask : '0;

  always_comb begin
    unique case (strobe.kind)
      TK_MASK:  takeLvl = LVL_W'(winIdx) + LVL_W'(2);
      TK_BREAK: takeLvl = LVL_W'(BRK_LEVEL);
      default:  takeLvl = LVL_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reqFlags <= '0;
      enFlags  <= '0;
      selBits  <= '0;
      polBits  <= '1;
      disFlag  <= 1'b1;
      vecReg   <= VEC_TOP;
    end else begin
      reqFlags <= (reqFlags & reqKeep & ~reqClr) | slotEvt;
      if (wrEn && wrAddr == REG_EN)  enFlags <= wrData;
      if (wrEn && wrAddr == REG_SEL) selBits <= wrData;
      if (wrEn && wrAddr == REG_POL) polBits <= wrData[PINS-1:0];
      if (strobe.take)                    disFlag <= 1'b1;
      else if (wrEn && wrAddr == REG_CTL) disFlag <= wrData[0];
      if (strobe.take) vecReg <= VEC_TOP - ((VEC_W'(takeLvl) - VEC_W'(1)) << 1);
    end
  end

  assign vecAddr = vecReg;

  always_comb begin
    unique case (rdAddr)
      REG_REQ: rdData = reqFlags;
      REG_EN:  rdData = enFlags;
      REG_SEL: rdData = selBits;
      REG_POL: rdData = SLOTS'(polBits);
      REG_CTL: rdData = SLOTS'(disFlag);
      default: rdData = '0;
    endcase
  end

  // R2: a maskable take only happens with an eligible slot and the disable flag clear
  a_r2_take_eligible: assert property (@(posedge clk) disable iff (rst)
    takeMask |-> (!disFlag && (|eligible)));
  // R6: every take leaves the disable flag set
  a_r6_disable_set: assert property (@(posedge clk) disable iff (rst)
    strobe.take |=> disFlag);
  // R6: the taken slot's flag is gone unless a fresh event refilled it
  a_r6_req_cleared: assert property (@(posedge clk) disable iff (rst)
    (takeMask && (slotEvt & winMask) == '0) |=> ((reqFlags & $past(winMask)) == '0));
  // R9: no hardware event is ever lost
  a_r9_event_kept: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((reqFlags & $past(slotEvt)) == $past(slotEvt)));
endmodule

// File: rtl/intc_control.sv
module intc_control
  import intc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       maskHit,
  input  logic       brkReq,
  input  logic       intAck,
  output ctlStrobe_t strobe,
  output logic       irqPending
);
  typedef enum logic {ST_IDLE, ST_HOLD} state_e;

  state_e state;
  logic   resetPend;

  always_comb begin
    strobe = '{take: 1'b0, kind: TK_NONE};
    if (state == ST_IDLE) begin
      if (resetPend)    strobe = '{take: 1'b1, kind: TK_RESET};
      else if (maskHit) strobe = '{take: 1'b1, kind: TK_MASK};
      else if (brkReq)  strobe = '{take: 1'b1, kind: TK_BREAK};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      resetPend <= 1'b1;
    end else begin
      if (strobe.take && strobe.kind == TK_RESET) resetPend <= 1'b0;
      unique case (state)
        ST_IDLE: if (strobe.take) state <= ST_HOLD;
        ST_HOLD: if (intAck)      state <= ST_IDLE;
        default:                  state <= ST_IDLE;
      endcase
    end
  end

  assign irqPending = (state == ST_HOLD);

  // R7: a take raises pending on the next edge
  a_r7_take_pends: assert property (@(posedge clk) disable iff (rst)
    strobe.take |=> irqPending);
  // R7: pending persists without acknowledge
  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (rst)
    (irqPending && !intAck) |=> irqPending);
  // R7: acknowledge retires the vector
  a_r7_ack_drops: assert property (@(posedge clk) disable iff (rst)
    (irqPending && intAck) |=> !irqPending);
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import intc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_PINS-1:0]  extPins,
  input  logic [NUM_PEVT-1:0]  periphEvt,
  input  logic                 brkReq,
  input  logic                 intAck,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    wrAddr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [ADDR_W-1:0]    rdAddr,
  output logic [DATA_W-1:0]    rdData,
  output logic                 irqPending,
  output logic [VEC_W-1:0]     vecAddr
);
  logic [NUM_PINS-1:0] pinEdge;
  logic [NUM_PINS-1:0] polBits;
  logic                maskHit;
  ctlStrobe_t          strobe;

  intc_pin_edge #(.PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst(rst), .pins(extPins), .polarity(polBits), .edges(pinEdge)
  );

  intc_datapath #(.SLOTS(NUM_SLOTS), .PINS(NUM_PINS), .PEVT(NUM_PEVT)) u_dp (
    .clk(clk), .rst(rst), .pinEdge(pinEdge), .periphEvt(periphEvt),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .strobe(strobe), .rdData(rdData), .polBits(polBits),
    .maskHit(maskHit), .vecAddr(vecAddr)
  );

  intc_control u_ctl (
    .clk(clk), .rst(rst), .maskHit(maskHit), .brkReq(brkReq),
    .intAck(intAck), .strobe(strobe), .irqPending(irqPending)
  );

  // R7: the presented vector does not move while awaiting acknowledge
  a_r7_vec_stable: assert property (@(posedge clk) disable iff (rst)
    (irqPending && !intAck) |=> $stable(vecAddr));
  // R8: break is only taken when no maskable slot qualifies
  a_r8_break_lowest: assert property (@(posedge clk) disable iff (rst)
    (strobe.take && strobe.kind == TK_BREAK) |-> !maskHit);
endmodule

// File: tb/prio_vec_intc_test.sv
module prio_vec_intc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  extPins = '0;
  logic [10:0] periphEvt = '0;
  logic        brkReq = 1'b0;
  logic        intAck = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [14:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [14:0] rdData;
  logic        irqPending;
  logic [15:0] vecAddr;

  int checks = 0;
  int errors = 0;

  localparam logic [2:0] A_REQ = 3'd0, A_EN = 3'd1, A_SEL = 3'd2, A_POL = 3'd3, A_CTL = 3'd4;

  prio_vec_intc uut (
    .clk(clk), .rst(rst), .extPins(extPins), .periphEvt(periphEvt),
    .brkReq(brkReq), .intAck(intAck), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .irqPending(irqPending), .vecAddr(vecAddr)
  );

  always #2 clk = ~clk;

  function automatic int priSrc(input int s);
    int t[15] = '{0, 1, 9, 10, 11, 12, 13, 14, 5, 6, 16, 2, 3, 4, 17};
    return t[s];
  endfunction

  function automatic int altOf(input int s);
    case (s)
      0: return 8;  9: return 15; 10: return 8; 13: return 7; 14: return 18;
      default: return -1;
    endcase
  endfunction

  function automatic logic [15:0] expVec(input int level);
    return 16'(32'hFFFC - 2 * (level - 1));
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [14:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    tick();
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] a, output logic [14:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic ackIt();
    intAck = 1'b1;
    tick();
    intAck = 1'b0;
  endtask

  task automatic fireSrc(input int src);
    if (src < 8) begin
      extPins[src] = 1'b1;
      repeat (4) tick();
      extPins[src] = 1'b0;
      repeat (4) tick();
    end else begin
      periphEvt[src-8] = 1'b1;
      tick();
      periphEvt[src-8] = 1'b0;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [14:0] rv;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1: reset vector first
    chk("R1", 16'(irqPending), 16'd1);
    chk("R1", vecAddr, 16'hFFFC);
    readReg(A_REQ, rv); chk("R1", 16'(rv), 16'h0);
    readReg(A_EN, rv);  chk("R1", 16'(rv), 16'h0);
    readReg(A_SEL, rv); chk("R1", 16'(rv), 16'h0);
    readReg(A_POL, rv); chk("R1", 16'(rv), 16'h00FF);
    readReg(A_CTL, rv); chk("R1", 16'(rv), 16'h1);
    ackIt();
    chk("R7", 16'(irqPending), 16'd0);

    writeReg(A_EN, 15'h7FFF);
    readReg(A_EN, rv); chk("R10", 16'(rv), 16'h7FFF);

    // Sweep every slot and every source choice.
    for (int s = 0; s < 15; s++) begin
      for (int sel = 0; sel < 2; sel++) begin
        int src;
        int other;
        if (sel == 1 && altOf(s) < 0) continue;
        src   = (sel == 1) ? altOf(s) : priSrc(s);
        other = (sel == 1) ? priSrc(s) : altOf(s);
        writeReg(A_SEL, 15'(sel << s));
        if (other >= 0) begin
          fireSrc(other);
          readReg(A_REQ, rv); chk("R4", 16'(rv), 16'h0);
        end
        fireSrc(src);
        readReg(A_REQ, rv); chk("R4", 16'(rv), 16'(1 << s));
        chk("R2", 16'(irqPending), 16'd0);
        writeReg(A_CTL, 15'h0);
        tick();
        chk("R3", 16'(irqPending), 16'd1);
        chk("R3", vecAddr, expVec(s + 2));
        readReg(A_REQ, rv); chk("R6", 16'(rv), 16'h0);
        readReg(A_CTL, rv); chk("R6", 16'(rv), 16'h1);
        repeat (3) tick();
        chk("R7", vecAddr, expVec(s + 2));
        chk("R7", 16'(irqPending), 16'd1);
        ackIt();
        chk("R7", 16'(irqPending), 16'd0);
      end
    end
    writeReg(A_SEL, 15'h0);

    // R3: two eligible slots, lower index first
    periphEvt = 11'h104;
    tick();
    periphEvt = '0;
    readReg(A_REQ, rv); chk("R3", 16'(rv), 16'h0408);
    writeReg(A_CTL, 15'h0);
    tick();
    chk("R3", vecAddr, 16'hFFF4);
    readReg(A_REQ, rv); chk("R6", 16'(rv), 16'h0400);
    ackIt();
    writeReg(A_CTL, 15'h0);
    tick();
    chk("R3", vecAddr, 16'hFFE6);
    ackIt();

    // R2: enable flag gates a request
    writeReg(A_EN, 15'h7FEF);
    fireSrc(11);
    writeReg(A_CTL, 15'h0);
    repeat (2) tick();
    chk("R2", 16'(irqPending), 16'd0);
    readReg(A_REQ, rv); chk("R2", 16'(rv), 16'h0010);
    writeReg(A_CTL, 15'h1);

    // R8: break taken while disable flag is set
    brkReq = 1'b1;
    tick();
    chk("R8", 16'(irqPending), 16'd1);
    chk("R8", vecAddr, 16'hFFDC);
    writeReg(A_EN, 15'h7FFF);
    intAck = 1'b1; wrEn = 1'b1; wrAddr = A_CTL; wrData = 15'h0;
    tick();
    intAck = 1'b0; wrEn = 1'b0;
    tick();
    // R8: maskable slot wins over a waiting break
    chk("R8", vecAddr, 16'hFFF2);
    ackIt();
    tick();
    chk("R8", 16'(irqPending), 16'd1);
    chk("R8", vecAddr, 16'hFFDC);
    intAck = 1'b1; brkReq = 1'b0;
    tick();
    intAck = 1'b0;
    tick();
    chk("R8", 16'(irqPending), 16'd0);

    // R5: falling-edge polarity on pin 2
    writeReg(A_POL, 15'h00FB);
    readReg(A_POL, rv); chk("R10", 16'(rv), 16'h00FB);
    extPins[2] = 1'b1;
    repeat (4) tick();
    readReg(A_REQ, rv); chk("R5", 16'(rv), 16'h0);
    extPins[2] = 1'b0;
    repeat (2) tick();
    readReg(A_REQ, rv); chk("R5", 16'(rv), 16'h0);
    tick();
    readReg(A_REQ, rv); chk("R5", 16'(rv), 16'h0800);

    // R9: write-0 clears, write-1 leaves, events survive a clear
    writeReg(A_REQ, 15'h0);
    readReg(A_REQ, rv); chk("R9", 16'(rv), 16'h0);
    writeReg(A_REQ, 15'h7FFF);
    readReg(A_REQ, rv); chk("R9", 16'(rv), 16'h0);
    fireSrc(9);
    readReg(A_REQ, rv); chk("R9", 16'(rv), 16'h0004);
    periphEvt[5] = 1'b1;
    writeReg(A_REQ, 15'h0);
    periphEvt[5] = 1'b0;
    readReg(A_REQ, rv); chk("R9", 16'(rv), 16'h0040);
    periphEvt[5] = 1'b1;
    writeReg(A_REQ, 15'h0);
    periphEvt[5] = 1'b0;
    readReg(A_REQ, rv); chk("R9", 16'(rv), 16'h0040);
    writeReg(A_REQ, 15'h0);

    // R10: register readback
    writeReg(A_SEL, 15'h5A5A);
    readReg(A_SEL, rv); chk("R10", 16'(rv), 16'h5A5A);
    readReg(3'd6, rv);  chk("R10", 16'(rv), 16'h0);
    readReg(A_CTL, rv); chk("R10", 16'(rv), 16'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule